// File: doc/BRIEF.md
# Multiplexed-Bus Modem Register Interface

This block is the host-facing register port of a modem controller. A host reaches it over an 8-bit bus that shares address and data on the same lines and uses an address strobe, a chip select and separate read and write strobes. On the falling edge of the address strobe the block captures a 3-bit register address together with the chip-select level. That pair governs the whole following read or write cycle. Four control registers and a tone register can be written and read back. A detect register collects event flags that the modem core reports as one-cycle pulses. It is read-only and clears when the host reads it.

Any detect flag that sets raises a sticky interrupt. The interrupt holds until the detect register has been read or the block is reset. A field in the first control register selects what drives the modem's clock output: the crystal clock, or a baud clock at sixteen times the data rate. The baud clock may be chosen only while the phase/quadrature modulation mode bit is also set.

Holding the address strobe high and the chip select low puts the pins into a reduced serial mode. In this mode bits 2..0 of the bus carry the address directly and bit 7 becomes a one-bit data line. All strobes and bus lines pass through two-flop synchronizers into the system clock domain.

Top module: `mdh_hostport`

## Requirements
- R1: On a falling edge of `ale_i` the block captures `ad_i[2:0]` as the register address and `cs_n_i` as the select level. Later bus changes do not alter the target of the cycle.
- R2: In parallel mode with the captured select low, a rising edge of `wr_n_i` writes `ad_i` into the addressed register. Addresses 0..3 go to control bytes 0..3, which appear on `ctrl_o[8*k+7:8*k]`. Address 4 goes to the tone register on `tone_o`.
- R3: In parallel mode `ad_oe_o` is high only while `rd_n_i` is low and the captured select is low. While it is high, `ad_o` carries the addressed register. Otherwise `ad_o` is zero.
- R4: With the captured select high, no register changes and `ad_oe_o` stays low, whatever the read and write strobes do.
- R5: A pulse on `det_pulse_i[i]` sets detect flag i, which is read at address 5 as bit i. It also drives `irq_o` high on the next cycle.
- R6: `irq_o` stays high until a read of address 5 completes or reset occurs. In parallel mode a read completes on the rising edge of `rd_n_i`. Completing the read clears all detect flags.
- R7: A detect pulse that arrives in the same cycle as the clearing read is kept. Its flag stays set and `irq_o` stays high.
- R8: Reset (`rst_n` low at a clock edge) clears all control bytes, the tone register, the detect flags and `irq_o`, and sets `clk_sel_o` to 0, which selects the crystal clock.
- R9: `clk_sel_o` is 1, which selects the 16x baud clock, only when control byte 0 has both bit 1 (baud-clock request) and bit 0 (phase/quadrature mode) set.
- R10: Addresses 5, 6 and 7 ignore writes. Addresses 6 and 7 read as zero.
- R11: The block is in serial mode while `ale_i` is high and `cs_n_i` is low. A serial write takes `ad_i[7]` on each rising edge of `wr_n_i`, least significant bit first. The register addressed by `ad_i[2:0]` updates only after the eighth bit.
- R12: In a serial read, `ad_oe_o` is high while `rd_n_i` is low, and `ad_o[7]` shows bit k of the addressed register, with `ad_o[6:0]` zero. k starts at 0 and advances on each rising edge of `rd_n_i`. After the eighth bit of address 5 the detect flags clear.
- R13: Strobe changes take effect through two synchronizer flops. `ad_oe_o` rises after the second clock edge following a fall of `rd_n_i`. A parallel write becomes visible after the third clock edge following the rise of `wr_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale_i | input | 1 | Address strobe; falling edge captures address and select |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low; data taken on its rising edge |
| ad_i | input | 8 | Address/data bus as seen at the pins |
| ad_o | output | 8 | Read data driven toward the bus |
| ad_oe_o | output | 1 | High while the block drives the bus |
| det_pulse_i | input | 8 | One-cycle detect events from the modem core |
| irq_o | output | 1 | Sticky interrupt request, active high |
| ctrl_o | output | 32 | Control bytes 0..3, byte k in bits 8k+7..8k |
| tone_o | output | 8 | Tone register |
| clk_sel_o | output | 1 | Clock output source: 0 crystal, 1 baud clock |

## Verification
The bench checks that a write hits the register captured at the address strobe, even when the data byte's low bits point elsewhere. A design that decoded the live bus would corrupt a neighbouring control byte. It places a detect pulse exactly on the clock edge of the clearing read. A design that lets the clear win would drop the flag and leave the interrupt low. It also checks that a serial write does not update the register after seven bits and that the serial read order is least significant bit first. Off-by-one counters or reversed shifts would then show up as wrong register values or wrong read-back. Deselected cycles, writes to the read-only and unused addresses, and the timing of the bus enable through the synchronizers are compared cycle by cycle against a behavioural model.

// File: rtl/mdh_pkg.sv
// Package: shared defaults and field positions for the modem host port.
// Assumes: control byte 0 carries the modulation-mode and clock-request bits.
package mdh_pkg;
    localparam int unsigned DATA_W_DEF   = 8;
    localparam int unsigned ADDR_W_DEF   = 3;
    localparam int unsigned N_CTL_DEF    = 4;
    localparam int unsigned DET_W_DEF    = 8;
    localparam int unsigned SYNC_STAGES  = 2;
    // Bit positions inside control byte 0 that steer the clock output mux.
    localparam int unsigned MODE_BIT     = 0;
    localparam int unsigned CLKREQ_BIT   = 1;
endpackage

// File: rtl/mdh_sync.sv
// Module: multi-bit synchronizer chain of STAGES flops into the clk domain.
// Assumes: each bit is an independent slow strobe or a bus held stable
// across the strobe edge that samples it.
module mdh_sync #(
    parameter int unsigned   W       = 1,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mdh_serial.sv
// Module: serial-mode bit engine. Assembles a write word from one data line
// (LSB first) and steps a read bit index, one bit per strobe rising edge.
// Assumes: counters restart whenever serial mode is left.
module mdh_serial #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_en,
    input  logic              wr_rise,
    input  logic              rd_rise,
    input  logic              bit_in,
    input  logic [DATA_W-1:0] rdata,
    output logic              wr_done,
    output logic [DATA_W-1:0] wword,
    output logic              rbit,
    output logic              rd_done
);
    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  wcnt_q, rcnt_q;
    logic [DATA_W-1:0] shreg_q;

    assign wword = {bit_in, shreg_q[DATA_W-1:1]};

    // Advance the write shifter and the two bit counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q  <= '0;
            rcnt_q  <= '0;
            shreg_q <= '0;
        end else if (!ser_en) begin
            wcnt_q <= '0;
            rcnt_q <= '0;
        end else begin
            if (wr_rise) begin
                shreg_q <= wword;
                wcnt_q  <= (wcnt_q == LAST) ? '0 : wcnt_q + 1'b1;
            end
            if (rd_rise) begin
                rcnt_q <= (rcnt_q == LAST) ? '0 : rcnt_q + 1'b1;
            end
        end
    end

    assign wr_done = ser_en & wr_rise & (wcnt_q == LAST);
    assign rd_done = ser_en & rd_rise & (rcnt_q == LAST);
    assign rbit    = rdata[rcnt_q];
endmodule

// File: rtl/mdh_regs.sv
// Module: control, tone and detect registers with the sticky interrupt.
// Assumes: one shared address for write and read; a detect pulse in the
// clearing cycle survives the clear.
module mdh_regs #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned N_CTL  = 4,
    parameter int unsigned DET_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [DET_W-1:0]        det_pulse,
    input  logic                    det_clr,
    output logic [DATA_W-1:0]       rdata,
    output logic [N_CTL*DATA_W-1:0] ctrl_flat,
    output logic [DATA_W-1:0]       tone,
    output logic                    irq
);
    localparam logic [ADDR_W-1:0] TONE_A = ADDR_W'(N_CTL);
    localparam logic [ADDR_W-1:0] DET_A  = ADDR_W'(N_CTL + 1);

    logic [DATA_W-1:0] ctl_q [N_CTL];
    logic [DATA_W-1:0] tone_q;
    logic [DET_W-1:0]  det_q;
    logic              irq_q;

    for (genvar g = 0; g < int'(N_CTL); g++) begin : g_ctl
        // Hold one control byte; load it when addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)                          ctl_q[g] <= '0;
            else if (we && addr == ADDR_W'(g))   ctl_q[g] <= wdata;
        end
        assign ctrl_flat[g*DATA_W +: DATA_W] = ctl_q[g];
    end

    // Hold the tone byte.
    always_ff @(posedge clk) begin
        if (!rst_n)                    tone_q <= '0;
        else if (we && addr == TONE_A) tone_q <= wdata;
    end

    // Collect detect flags and keep the interrupt sticky; new sets beat clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
            irq_q <= 1'b0;
        end else begin
            det_q <= (det_clr ? '0 : det_q) | det_pulse;
            if (|det_pulse)   irq_q <= 1'b1;
            else if (det_clr) irq_q <= 1'b0;
        end
    end

    // Read mux; unused addresses return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < int'(N_CTL); i++) begin
            if (addr == ADDR_W'(i)) rdata = ctl_q[i];
        end
        if (addr == TONE_A) rdata = tone_q;
        if (addr == DET_A)  rdata[DET_W-1:0] = det_q;
    end

    assign tone = tone_q;
    assign irq  = irq_q;
endmodule

// File: rtl/mdh_hostport.sv
// Module: top of the modem host register port. Synchronizes the bus pins,
// captures address and select on the address-strobe fall, and steers
// parallel or serial accesses into the register bank.
// Assumes: the bus is held stable across each strobe edge long enough for
// the synchronizers; serial mode is the level pair ale high, cs low.
module mdh_hostport #(
    parameter int unsigned DATA_W = mdh_pkg::DATA_W_DEF,
    parameter int unsigned ADDR_W = mdh_pkg::ADDR_W_DEF,
    parameter int unsigned N_CTL  = mdh_pkg::N_CTL_DEF,
    parameter int unsigned DET_W  = mdh_pkg::DET_W_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ale_i,
    input  logic                    cs_n_i,
    input  logic                    rd_n_i,
    input  logic                    wr_n_i,
    input  logic [DATA_W-1:0]       ad_i,
    output logic [DATA_W-1:0]       ad_o,
    output logic                    ad_oe_o,
    input  logic [DET_W-1:0]        det_pulse_i,
    output logic                    irq_o,
    output logic [N_CTL*DATA_W-1:0] ctrl_o,
    output logic [DATA_W-1:0]       tone_o,
    output logic                    clk_sel_o
);
    localparam int unsigned        SW     = DATA_W + 4;
    localparam logic [SW-1:0]      S_IDLE = {1'b0, 3'b111, {DATA_W{1'b0}}};
    localparam logic [ADDR_W-1:0]  DET_A  = ADDR_W'(N_CTL + 1);

    logic [SW-1:0]     raw_bus, sync_bus;
    logic              s_ale, s_cs_n, s_rd_n, s_wr_n;
    logic [DATA_W-1:0] s_ad;
    logic              ale_prev, rd_prev, wr_prev;
    logic              ale_fall, rd_rise, wr_rise;
    logic              cs_lat;
    logic [ADDR_W-1:0] addr_lat;
    logic              ser_mode, par_sel;
    logic              ser_wr_done, ser_rd_done, ser_bit;
    logic [DATA_W-1:0] ser_word;
    logic              we;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] wdata, rdata;
    logic              det_clr;

    assign raw_bus = {ale_i, cs_n_i, rd_n_i, wr_n_i, ad_i};

    mdh_sync #(.W(SW), .STAGES(mdh_pkg::SYNC_STAGES), .RST_VAL(S_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
    );

    assign {s_ale, s_cs_n, s_rd_n, s_wr_n, s_ad} = sync_bus;

    // Remember the previous synchronized strobe levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_prev <= 1'b0;
            rd_prev  <= 1'b1;
            wr_prev  <= 1'b1;
        end else begin
            ale_prev <= s_ale;
            rd_prev  <= s_rd_n;
            wr_prev  <= s_wr_n;
        end
    end

    assign ale_fall = ale_prev & ~s_ale;
    assign rd_rise  = ~rd_prev & s_rd_n;
    assign wr_rise  = ~wr_prev & s_wr_n;

    // Capture address and select together on the address-strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_lat   <= 1'b1;
            addr_lat <= '0;
        end else if (ale_fall) begin
            cs_lat   <= s_cs_n;
            addr_lat <= s_ad[ADDR_W-1:0];
        end
    end

    assign ser_mode = s_ale & ~s_cs_n;
    assign par_sel  = ~ser_mode & ~cs_lat;

    mdh_serial #(.DATA_W(DATA_W)) u_serial (
        .clk(clk), .rst_n(rst_n), .ser_en(ser_mode),
        .wr_rise(wr_rise), .rd_rise(rd_rise), .bit_in(s_ad[DATA_W-1]),
        .rdata(rdata), .wr_done(ser_wr_done), .wword(ser_word),
        .rbit(ser_bit), .rd_done(ser_rd_done)
    );

    assign acc_addr = ser_mode ? s_ad[ADDR_W-1:0] : addr_lat;
    assign wdata    = ser_mode ? ser_word : s_ad;
    assign we       = (par_sel & wr_rise) | ser_wr_done;
    assign det_clr  = (acc_addr == DET_A) & ((par_sel & rd_rise) | ser_rd_done);

    mdh_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_CTL(N_CTL), .DET_W(DET_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(acc_addr), .wdata(wdata),
        .det_pulse(det_pulse_i), .det_clr(det_clr), .rdata(rdata),
        .ctrl_flat(ctrl_o), .tone(tone_o), .irq(irq_o)
    );

    // Bus drive: serial reads drive the top bit only, parallel the whole byte.
    always_comb begin
        ad_oe_o = ser_mode ? ~s_rd_n : (par_sel & ~s_rd_n);
        ad_o    = '0;
        if (ad_oe_o) ad_o = ser_mode ? {ser_bit, {(DATA_W-1){1'b0}}} : rdata;
    end

    assign clk_sel_o = ctrl_o[mdh_pkg::MODE_BIT] & ctrl_o[mdh_pkg::CLKREQ_BIT];
endmodule

// File: rtl/mdh_hostport_chk.sv
// Module: property checker for the host port, bound into every instance.
// Assumes: internal nets ser_mode, cs_lat and det_clr exist in the top.
module mdh_hostport_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned N_CTL  = 4,
    parameter int unsigned DET_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rd_n_i,
    input logic                    ad_oe_o,
    input logic [DET_W-1:0]        det_pulse_i,
    input logic                    irq_o,
    input logic [N_CTL*DATA_W-1:0] ctrl_o,
    input logic [DATA_W-1:0]       tone_o,
    input logic                    ser_mode,
    input logic                    cs_lat,
    input logic                    det_clr
);
    logic [1:0] cyc_q;

    // Count clean cycles since reset so history checks stay inside them.
    always_ff @(posedge clk) begin
        if (!rst_n)           cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    a_r3_drive_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2 && ad_oe_o) |-> !$past(rd_n_i, 2));

    a_r4_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && cs_lat) |-> !ad_oe_o);

    a_r4_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode && cs_lat) |=> ($stable(ctrl_o) && $stable(tone_o)));

    a_r5_irq_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|det_pulse_i) |=> irq_o);

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !det_clr) |=> irq_o);

    a_r6_irq_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(det_clr));

    a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (det_clr && |det_pulse_i) |=> irq_o);
endmodule

bind mdh_hostport mdh_hostport_chk #(.DATA_W(DATA_W), .N_CTL(N_CTL), .DET_W(DET_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_n_i(rd_n_i), .ad_oe_o(ad_oe_o),
    .det_pulse_i(det_pulse_i), .irq_o(irq_o), .ctrl_o(ctrl_o), .tone_o(tone_o),
    .ser_mode(ser_mode), .cs_lat(cs_lat), .det_clr(det_clr)
);

// File: tb/mdh_hostport_tb_top.sv
// Bench: behavioural cycle model compared on every clock, plus directed
// checks per requirement.
module mdh_hostport_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  ad = 8'h00;
    logic [7:0]  det = 8'h00;
    logic [7:0]  ad_o;
    logic        ad_oe_o, irq_o, clk_sel_o;
    logic [31:0] ctrl_o;
    logic [7:0]  tone_o;

    int n_chk = 0, n_bad = 0, wd = 0;
    bit done = 0, armed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdh_hostport dut_i (
        .clk(clk), .rst_n(rst_n), .ale_i(ale), .cs_n_i(cs_n), .rd_n_i(rd_n),
        .wr_n_i(wr_n), .ad_i(ad), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
        .det_pulse_i(det), .irq_o(irq_o), .ctrl_o(ctrl_o), .tone_o(tone_o),
        .clk_sel_o(clk_sel_o)
    );

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural model ----------------
    // history words: {ale, cs_n, rd_n, wr_n, ad[7:0]}; h1 newest seen
    localparam logic [11:0] IDLE = 12'b0111_0000_0000;
    logic [11:0] h1, h2, h3;
    logic [7:0]  m_ctl [4];
    logic [7:0]  m_tone, m_det, m_sh;
    logic        m_irq, m_cs;
    logic [2:0]  m_addr;
    int          m_wc, m_rc;

    function automatic logic [7:0] m_read(logic [2:0] a);
        if (a < 3'd4)  return m_ctl[a];
        if (a == 3'd4) return m_tone;
        if (a == 3'd5) return m_det;
        return 8'h00;
    endfunction

    task automatic m_write(logic [2:0] a, logic [7:0] d);
        if (a < 3'd4) m_ctl[a] = d;
        else if (a == 3'd4) m_tone = d;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 = IDLE; h2 = IDLE; h3 = IDLE;
            for (int i = 0; i < 4; i++) m_ctl[i] = 8'h00;
            m_tone = 0; m_det = 0; m_sh = 0; m_irq = 0; m_cs = 1; m_addr = 0;
            m_wc = 0; m_rc = 0;
            armed = 1;
        end else begin
            bit ser_o, wr_r, rd_r, ale_f, clr;
            ser_o = h2[11] && !h2[10];
            wr_r  = !h3[8] && h2[8];
            rd_r  = !h3[9] && h2[9];
            ale_f = h3[11] && !h2[11];
            clr   = 0;
            if (ser_o) begin
                if (wr_r) begin
                    logic [7:0] nb;
                    nb = {h2[7], m_sh[7:1]};
                    m_sh = nb;
                    if (m_wc == 7) begin m_write(h2[2:0], nb); m_wc = 0; end
                    else m_wc++;
                end
                if (rd_r) begin
                    if (m_rc == 7) begin
                        if (h2[2:0] == 3'd5) clr = 1;
                        m_rc = 0;
                    end else m_rc++;
                end
            end else begin
                m_wc = 0; m_rc = 0;
                if (wr_r && !m_cs) m_write(m_addr, h2[7:0]);
                if (rd_r && !m_cs && m_addr == 3'd5) clr = 1;
            end
            if (ale_f) begin m_cs = h2[10]; m_addr = h2[2:0]; end
            m_det = (clr ? 8'h00 : m_det) | det;
            if (|det) m_irq = 1; else if (clr) m_irq = 0;
            h3 = h2; h2 = h1; h1 = {ale, cs_n, rd_n, wr_n, ad};
        end
    end

    // Compare every cycle at the falling edge.
    always @(negedge clk) begin
        if (rst_n && armed && !done) begin
            bit ser, oe;
            logic [7:0] e_ad, rv;
            ser = h2[11] && !h2[10];
            oe  = ser ? !h2[9] : (!m_cs && !h2[9]);
            e_ad = 8'h00;
            if (oe) begin
                if (ser) begin rv = m_read(h2[2:0]); e_ad = {rv[m_rc[2:0]], 7'b0}; end
                else e_ad = m_read(m_addr);
            end
            chk("R3/R12 model ad_oe_o", 32'(ad_oe_o), 32'(oe));
            chk("R3/R12 model ad_o", 32'(ad_o), 32'(e_ad));
            chk("R2/R11 model ctrl_o", ctrl_o, {m_ctl[3], m_ctl[2], m_ctl[1], m_ctl[0]});
            chk("R2/R11 model tone_o", 32'(tone_o), 32'(m_tone));
            chk("R5/R6 model irq_o", 32'(irq_o), 32'(m_irq));
            chk("R9 model clk_sel_o", 32'(clk_sel_o), 32'(m_ctl[0][1] & m_ctl[0][0]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0; ale = 0; cs_n = 1; rd_n = 1; wr_n = 1; ad = 0; det = 0;
        tick(3);
        rst_n = 1;
        tick(1);
    endtask

    task automatic latch(logic [2:0] a, logic csn);
        ale = 1; cs_n = csn; ad = {5'b0, a};
        tick(3);
        ale = 0;
        tick(3);
        cs_n = 1;
    endtask

    task automatic pwrite(logic [2:0] a, logic [7:0] d, logic csn);
        latch(a, csn);
        ad = d; wr_n = 0;
        tick(3);
        wr_n = 1;
        tick(4);
    endtask

    task automatic pread(logic [2:0] a, logic csn, output logic [7:0] v, output logic oe);
        latch(a, csn);
        rd_n = 0;
        tick(4);
        v = ad_o; oe = ad_oe_o;
        rd_n = 1;
        tick(4);
    endtask

    task automatic pulse(logic [7:0] m);
        det = m;
        tick(1);
        det = 0;
    endtask

    task automatic ser_enter(logic [2:0] a);
        ale = 1; cs_n = 0; ad = {5'b0, a};
        tick(3);
    endtask

    task automatic ser_exit();
        cs_n = 1;
        tick(3);
        ale = 0;
        tick(3);
    endtask

    task automatic ser_bit(logic b);
        ad[7] = b;
        tick(1);
        wr_n = 0;
        tick(3);
        wr_n = 1;
        tick(3);
    endtask

    task automatic ser_read(output logic [7:0] v, output int oe_cnt);
        oe_cnt = 0;
        for (int k = 0; k < 8; k++) begin
            rd_n = 0;
            tick(3);
            v[k] = ad_o[7];
            if (ad_oe_o && ad_o[6:0] == 7'd0) oe_cnt++;
            rd_n = 1;
            tick(3);
        end
    endtask

    task automatic report();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        wd++;
        if (wd > WD_LIMIT && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual %0d expected below %0d cycles", wd, WD_LIMIT);
            report();
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        logic [7:0] v;
        logic       oe;
        int         oc;
        do_reset();
        // R8: reset state
        chk("R8 reset ctrl_o", ctrl_o, 32'h0);
        chk("R8 reset tone_o", 32'(tone_o), 32'h0);
        chk("R8 reset irq_o", 32'(irq_o), 32'h0);
        chk("R8 reset clk_sel_o", 32'(clk_sel_o), 32'h0);
        chk("R8 reset ad_oe_o", 32'(ad_oe_o), 32'h0);

        // R2 / R3: write then read back control byte 1
        pwrite(3'd1, 8'hA5, 1'b0);
        chk("R2 write CR1", 32'(ctrl_o[15:8]), 32'hA5);
        pread(3'd1, 1'b0, v, oe);
        chk("R3 read CR1 data", 32'(v), 32'hA5);
        chk("R3 read CR1 oe", 32'(oe), 32'h1);
        chk("R3 oe released", 32'(ad_oe_o), 32'h0);

        // R13 write latency and R9 clock select
        latch(3'd0, 1'b0);
        ad = 8'h03; wr_n = 0;
        tick(3);
        wr_n = 1;
        tick(2);
        chk("R13 write not yet visible", 32'(ctrl_o[7:0]), 32'h00);
        tick(1);
        chk("R13 write visible third edge", 32'(ctrl_o[7:0]), 32'h03);
        chk("R9 both bits select baud", 32'(clk_sel_o), 32'h1);
        tick(3);
        pwrite(3'd0, 8'h02, 1'b0);
        chk("R9 request without mode", 32'(clk_sel_o), 32'h0);
        pwrite(3'd0, 8'h01, 1'b0);
        chk("R9 mode without request", 32'(clk_sel_o), 32'h0);

        // R13 read enable latency
        latch(3'd1, 1'b0);
        rd_n = 0;
        tick(1);
        chk("R13 oe low after one edge", 32'(ad_oe_o), 32'h0);
        tick(1);
        chk("R13 oe high after two edges", 32'(ad_oe_o), 32'h1);
        rd_n = 1;
        tick(4);

        // R4: deselected write and read
        pwrite(3'd2, 8'h77, 1'b1);
        chk("R4 deselected write ignored", 32'(ctrl_o[23:16]), 32'h00);
        pread(3'd1, 1'b1, v, oe);
        chk("R4 deselected read no drive", 32'(oe), 32'h0);
        chk("R4 deselected read data", 32'(v), 32'h00);

        // R1: data low bits point at CR3, captured address is CR2
        pwrite(3'd2, 8'hFB, 1'b0);
        chk("R1 captured address CR2", 32'(ctrl_o[23:16]), 32'hFB);
        chk("R1 CR3 untouched", 32'(ctrl_o[31:24]), 32'h00);

        // R2 tone; R10 read-only and unused addresses
        pwrite(3'd4, 8'hC3, 1'b0);
        chk("R2 tone write", 32'(tone_o), 32'hC3);
        pwrite(3'd5, 8'h33, 1'b0);
        pwrite(3'd6, 8'h11, 1'b0);
        pwrite(3'd7, 8'h22, 1'b0);
        chk("R10 writes ignored ctrl", ctrl_o, 32'h00FB_A501);
        chk("R10 writes ignored tone", 32'(tone_o), 32'hC3);
        chk("R10 detect write no irq", 32'(irq_o), 32'h0);
        pread(3'd5, 1'b0, v, oe);
        chk("R10 detect stays clear", 32'(v), 32'h00);
        pread(3'd6, 1'b0, v, oe);
        chk("R10 address 6 reads zero", 32'(v), 32'h00);
        pread(3'd7, 1'b0, v, oe);
        chk("R10 address 7 reads zero", 32'(v), 32'h00);

        // R5 / R6: flag and sticky interrupt
        pulse(8'h08);
        chk("R5 irq after pulse", 32'(irq_o), 32'h1);
        pread(3'd4, 1'b0, v, oe);
        chk("R6 irq kept over other read", 32'(irq_o), 32'h1);
        pread(3'd5, 1'b0, v, oe);
        chk("R5 detect bit 3", 32'(v), 32'h08);
        chk("R6 irq cleared by detect read", 32'(irq_o), 32'h0);

        // R7: pulse lands on the clearing edge
        pulse(8'h01);
        latch(3'd5, 1'b0);
        rd_n = 0;
        tick(4);
        chk("R7 detect before clear", 32'(ad_o), 32'h01);
        rd_n = 1;
        tick(2);
        det = 8'h40;
        tick(1);
        det = 8'h00;
        tick(2);
        chk("R7 irq kept on same-cycle set", 32'(irq_o), 32'h1);
        pread(3'd5, 1'b0, v, oe);
        chk("R7 new flag kept, old cleared", 32'(v), 32'h40);
        chk("R7 irq cleared on next read", 32'(irq_o), 32'h0);

        // R11: serial write to CR3, LSB first
        ser_enter(3'd3);
        for (int k = 0; k < 7; k++) ser_bit(8'h96 >> k);
        chk("R11 no update after seven bits", 32'(ctrl_o[31:24]), 32'h00);
        ser_bit(1'b1);
        chk("R11 update after eighth bit", 32'(ctrl_o[31:24]), 32'h96);
        ser_exit();

        // R12: serial read back, detect clear, unused address
        ser_enter(3'd3);
        ser_read(v, oc);
        chk("R12 serial read CR3", 32'(v), 32'h96);
        chk("R12 serial drive only bit 7", 32'(oc), 32'd8);
        ser_exit();
        pulse(8'h21);
        ser_enter(3'd5);
        ser_read(v, oc);
        chk("R12 serial read detect", 32'(v), 32'h21);
        ser_exit();
        chk("R12 serial detect read clears irq", 32'(irq_o), 32'h0);
        ser_enter(3'd7);
        ser_read(v, oc);
        chk("R12 serial address 7 zero", 32'(v), 32'h00);
        ser_exit();

        // R8: reset after activity
        pwrite(3'd0, 8'h03, 1'b0);
        pulse(8'h80);
        do_reset();
        chk("R8 reset clears ctrl", ctrl_o, 32'h0);
        chk("R8 reset clears tone", 32'(tone_o), 32'h0);
        chk("R8 reset clears irq", 32'(irq_o), 32'h0);
        chk("R8 reset crystal clock", 32'(clk_sel_o), 32'h0);
        pread(3'd5, 1'b0, v, oe);
        chk("R8 reset clears detect", 32'(v), 32'h00);

        tick(2);
        report();
    end
endmodule